// File: doc/BRIEF.md
# Pin-Shared GPIO Port with Interrupt Routing

This block is an eight-pin general-purpose I/O port reached through a byte-wide register bus. Each pin has three programmable bits. A select bit chooses between GPIO mode and the pin's fixed interrupt-request role. A direction bit chooses between driving the pin and sensing it. A data latch holds the value to drive. On the pad side the port sees the pin input level and produces an output value and an output enable for each pin.

A pin whose select bit is clear is released to its interrupt function. The port stops driving that pin and forwards the pin's synchronized level on the matching interrupt line. Edge or level detection and prioritisation of those lines happen downstream. The data latch accepts writes at any time, but a reading of the data offset always returns the live, synchronized pin level and never the latch contents.

Top module: `gpio_port_mux`

## Requirements
- R1: After reset the select register reads 0xFF, the direction register reads 0x00 and the data latch holds 0xFF. Every pin is then a GPIO input, so padOe, padOut and irqReq are all 0x00.
- R2: A bus write with busWrEn high is captured on that clock edge. The new register contents are visible on outputs and readback from the following cycle. The register offsets are 0x418 (direction), 0x419 (data) and 0x41B (select).
- R3: A pin with select=1 and direction=1 has padOe=1, and padOut equals its data latch bit (0 drives low, 1 drives high).
- R4: A pin with direction=0, or with select=0, has padOe=0.
- R5: Data written while a pin is an input is held in the latch. It appears on padOut once that pin becomes an output, with no further data write.
- R6: A read of offset 0x419 returns the pin levels through a two-flop synchronizer. A pin change shows on readback after two clock edges, whatever the pin's direction. The synchronizer resets to all ones.
- R7: For a pin with select=0, its irqReq bit equals the synchronized pin level. For a pin with select=1, its irqReq bit is 0. The bit mapping is: bits 0 to 3 are INT0 to INT3, and bits 4 to 7 are IRQ1, IRQ2, IRQ3 and IRQ6.
- R8: A read of any offset other than 0x418, 0x419 or 0x41B returns 0x00.
- R9: padOut is 0 for every pin whose padOe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 12 | Register byte offset |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, combinational from busAddr |
| padIn | input | 8 | Pin input levels |
| padOut | output | 8 | Pin output values |
| padOe | output | 8 | Pin output enables |
| irqReq | output | 8 | Interrupt request lines (INT0-3, IRQ1, IRQ2, IRQ3, IRQ6) |

## Verification
Two functions can fall in the same cycle: a data-latch write and the data readback. The write lands in the latch, while readback at the same offset keeps showing the synchronized pin level. The bench provokes this by writing a latch value that differs from the applied pin level while the pins are outputs. It then reads offset 0x419 and expects the pin level, and separately checks that padOut carries the written value. A second overlap occurs when the select register changes while a pin level is in flight through the synchronizer. This is judged by checking that padOe falls and irqReq takes the synchronized level in the cycle after the select write.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_DIR  = 2'd1,
    RD_DATA = 2'd2,
    RD_SEL  = 2'd3
  } rdSrc_e;

  typedef struct packed {
    logic   wrSel;
    logic   wrDir;
    logic   wrData;
    rdSrc_e rdSrc;
  } portStrobe_t;

endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] OFS_DIR  = 12'h418,
  parameter logic [ADDR_W-1:0] OFS_DATA = 12'h419,
  parameter logic [ADDR_W-1:0] OFS_SEL  = 12'h41B
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output portStrobe_t       strobe
);

  logic hitDir, hitData, hitSel;

  always_comb begin
    hitDir  = (busAddr == OFS_DIR);
    hitData = (busAddr == OFS_DATA);
    hitSel  = (busAddr == OFS_SEL);

    strobe.wrDir  = busWrEn && hitDir;
    strobe.wrData = busWrEn && hitData;
    strobe.wrSel  = busWrEn && hitSel;

    if (hitDir)       strobe.rdSrc = RD_DIR;
    else if (hitData) strobe.rdSrc = RD_DATA;
    else if (hitSel)  strobe.rdSrc = RD_SEL;
    else              strobe.rdSrc = RD_NONE;
  end

endmodule

// File: rtl/gpio_port_datapath.sv
module gpio_port_datapath
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  portStrobe_t      strobe,
  input  logic [WIDTH-1:0] busWrData,
  output logic [WIDTH-1:0] busRdData,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padOe,
  output logic [WIDTH-1:0] irqReq
);

  localparam logic [WIDTH-1:0] ALL_ONES = '1;

  logic [WIDTH-1:0] selReg, dirReg, dataLatch;
  logic [WIDTH-1:0] syncStage [SYNC_STAGES];
  logic [WIDTH-1:0] pinLevel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg    <= ALL_ONES;
      dirReg    <= '0;
      dataLatch <= ALL_ONES;
    end else begin
      if (strobe.wrSel)  selReg    <= busWrData;
      if (strobe.wrDir)  dirReg    <= busWrData;
      if (strobe.wrData) dataLatch <= busWrData;
    end
  end

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncStage[s] <= ALL_ONES;
        else if (s == 0) syncStage[s] <= padIn;
        else syncStage[s] <= syncStage[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign pinLevel = syncStage[SYNC_STAGES-1];

  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_pin
      logic driveEn;
      assign driveEn   = selReg[b] & dirReg[b];
      assign padOe[b]  = driveEn;
      assign padOut[b] = driveEn & dataLatch[b];
      assign irqReq[b] = ~selReg[b] & pinLevel[b];
    end
  endgenerate

  always_comb begin
    unique case (strobe.rdSrc)
      RD_DIR:  busRdData = dirReg;
      RD_DATA: busRdData = pinLevel;
      RD_SEL:  busRdData = selReg;
      default: busRdData = '0;
    endcase
  end

endmodule

// File: rtl/gpio_port_mux.sv
module gpio_port_mux
  import gpio_port_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [WIDTH-1:0]  busWrData,
  output logic [WIDTH-1:0]  busRdData,
  input  logic [WIDTH-1:0]  padIn,
  output logic [WIDTH-1:0]  padOut,
  output logic [WIDTH-1:0]  padOe,
  output logic [WIDTH-1:0]  irqReq
);

  portStrobe_t strobe;

  gpio_port_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strobe  (strobe)
  );

  gpio_port_datapath #(.WIDTH(WIDTH), .SYNC_STAGES(2)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .padIn     (padIn),
    .padOut    (padOut),
    .padOe     (padOe),
    .irqReq    (irqReq)
  );

endmodule

// File: rtl/gpio_port_mux_chk.sv
module gpio_port_mux_chk #(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [WIDTH-1:0]  busWrData,
  input logic [WIDTH-1:0]  busRdData,
  input logic [WIDTH-1:0]  padIn,
  input logic [WIDTH-1:0]  padOut,
  input logic [WIDTH-1:0]  padOe,
  input logic [WIDTH-1:0]  irqReq
);

  logic [1:0] cyc;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  AST_SEL_CLEAR_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 12'h41B) |=> ((padOe & ~$past(busWrData)) == '0)); // R4

  AST_DIR_CLEAR_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 12'h418) |=> ((padOe & ~$past(busWrData)) == '0)); // R4

  AST_DATA_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 12'h419) |=> (((padOut ^ $past(busWrData)) & padOe) == '0)); // R3

  AST_IRQ_ONLY_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    ((irqReq & padOe) == '0)); // R7

  AST_UNDRIVEN_LOW: assert property (@(posedge clk) disable iff (!rstN)
    ((padOut & ~padOe) == '0)); // R9

  AST_READBACK_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    (cyc >= 2'd2 && busAddr == 12'h419) |-> (busRdData == $past(padIn, 2))); // R6

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr != 12'h418 && busAddr != 12'h419 && busAddr != 12'h41B) |-> (busRdData == '0)); // R8

endmodule

bind gpio_port_mux gpio_port_mux_chk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busWrData (busWrData),
  .busRdData (busRdData),
  .padIn     (padIn),
  .padOut    (padOut),
  .padOe     (padOe),
  .irqReq    (irqReq)
);

// File: tb/test_gpio_port_mux.sv
`timescale 1ns/1ps
module test_gpio_port_mux;

  localparam logic [11:0] A_DIR  = 12'h418;
  localparam logic [11:0] A_DATA = 12'h419;
  localparam logic [11:0] A_SEL  = 12'h41B;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [7:0]  busWrData = '0;
  logic [7:0]  busRdData;
  logic [7:0]  padIn = 8'hFF;
  logic [7:0]  padOut, padOe, irqReq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_port_mux i_gpio_port_mux (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .irqReq(irqReq)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWrEn = 1'b0; busAddr = 12'h000;
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] d);
    busAddr = a;
    #1;
    d = busRdData;
    busAddr = 12'h000;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(A_SEL, v);  chk("R1", "select reset", v, 8'hFF);
    rd(A_DIR, v);  chk("R1", "direction reset", v, 8'h00);
    rd(A_DATA, v); chk("R6", "readback reset", v, 8'hFF);
    chk("R1", "padOe reset", padOe, 8'h00);
    chk("R1", "padOut reset", padOut, 8'h00);
    chk("R1", "irqReq reset", irqReq, 8'h00);
  endtask

  task automatic t_drive();
    logic [7:0] v;
    wr(A_DIR, 8'h0F);
    rd(A_DIR, v); chk("R2", "direction readback", v, 8'h0F);
    chk("R4", "padOe half output", padOe, 8'h0F);
    chk("R3", "padOut from reset latch", padOut, 8'h0F);
    wr(A_DATA, 8'hA5);
    chk("R3", "padOut after data write", padOut, 8'h05);
    chk("R9", "undriven pins low", padOut & ~padOe, 8'h00);
  endtask

  task automatic t_latch();
    wr(A_DATA, 8'h3C);
    chk("R5", "input bits hidden", padOut, 8'h0C);
    wr(A_DIR, 8'hFF);
    chk("R5", "latched value appears", padOut, 8'h3C);
    chk("R3", "all outputs enabled", padOe, 8'hFF);
  endtask

  task automatic t_read();
    logic [7:0] v;
    @(negedge clk);
    padIn = 8'h5A;
    @(posedge clk); @(negedge clk);
    rd(A_DATA, v); chk("R6", "readback after one edge", v, 8'hFF);
    @(posedge clk); @(negedge clk);
    rd(A_DATA, v); chk("R6", "readback after two edges (outputs)", v, 8'h5A);
    wr(A_DATA, 8'h11);
    rd(A_DATA, v); chk("R6", "readback ignores latch", v, 8'h5A);
    chk("R3", "padOut follows new latch", padOut, 8'h11);
    wr(A_DIR, 8'h00);
    rd(A_DATA, v); chk("R6", "readback as inputs", v, 8'h5A);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    wr(A_DIR, 8'hFF);
    wr(A_SEL, 8'hF0);
    rd(A_SEL, v); chk("R2", "select readback", v, 8'hF0);
    chk("R4", "released pins not driven", padOe, 8'hF0);
    chk("R7", "INT lines carry pin level", irqReq, 8'h0A);
    @(negedge clk);
    padIn = 8'h05;
    @(posedge clk); @(negedge clk);
    chk("R7", "INT lines before sync", irqReq, 8'h0A);
    @(posedge clk); @(negedge clk);
    chk("R7", "INT lines after sync", irqReq, 8'h05);
    wr(A_SEL, 8'h0F);
    padIn = 8'hF0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R7", "IRQ1/2/3/6 lines", irqReq, 8'hF0);
  endtask

  task automatic t_unmapped();
    logic [7:0] v;
    rd(12'h41A, v); chk("R8", "gap offset", v, 8'h00);
    rd(12'h000, v); chk("R8", "offset zero", v, 8'h00);
    wr(12'h41A, 8'h00);
    chk("R8", "unmapped write harmless", padOe, 8'h0F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_drive();
    t_latch();
    t_read();
    t_irq();
    t_unmapped();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule